// File: doc/BRIEF.md
# LED Channel Command Slave on I2C

This block is an I2C target with a fixed 7-bit device address. It turns short write frames into register updates for an eight-channel LED driver. After the address, the first byte holds a 3-bit command in its upper bits and a 5-bit register index in its lower bits. A data byte may follow. Each channel has a 5-bit current level and a 6-bit PWM duty code, and one 8-bit word switches the channels on and off. All writes go into a staged copy. The outputs that drive the channels change only when a command copies the staged copy into the active set.

The host reads a register in two steps. It writes a single-register command that carries the wanted index, then sends a repeated START with the read bit set. The slave returns that register's staged value, or the external status byte. SCL and SDA pass through two-flop synchronizers on the system clock, and START and STOP are detected as SDA edges while SCL is high. Every detected START produces a one-cycle pulse for the power-state logic.

Top module: `led_cmd_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address 7'h1B. The eighth address bit selects the direction: 0 for write, 1 for read. A frame to any other address is not acknowledged and changes no state.
- R2: The byte after a write address is acknowledged and decoded as command = bits 7:5 and index = bits 4:0. A data byte that follows a command byte is also acknowledged.
- R3: Command 3'b001 with a data byte writes the addressed staged register. The active outputs do not change.
- R4: Command 3'b000 copies every staged register into the active outputs. Its index is ignored, any data byte after it is ignored, and a STOP may follow the command byte directly.
- R5: Command 3'b010 writes the addressed staged register and then copies all staged registers to the active outputs, within the same frame.
- R6: Command 3'b011 loads the low 5 bits of the data byte into all eight staged current levels. Command 3'b100 loads the low 6 bits into all eight staged duty codes. The index is ignored and the active outputs do not change.
- R7: Commands 3'b101, 3'b110 and 3'b111 are acknowledged, together with their data byte, and change no register.
- R8: Register map: indices 0x00–0x07 are the levels of channels 0–7 (a write keeps the low 5 bits), 0x08–0x0F are the duty codes (a write keeps the low 6 bits), 0x10 is the channel enable word (bit n = channel n), and 0x11 returns status_i. A read after command 3'b001 and a repeated START returns the zero-extended value at the index. Unmapped indices read 0x00.
- R9: A write to index 0x11 or to any index above 0x11 is discarded.
- R10: After reset every staged and active register is zero and SDA is released.
- R11: bus_activity_o pulses for exactly one cycle on every START, including a repeated START.
- R12: The slave starts pulling SDA low only while the synchronized SCL is low, and it releases SDA after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the bus, asynchronous |
| status_i | input | 8 | Read-only status byte returned at index 0x11 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| bus_activity_o | output | 1 | One-cycle pulse per detected START |
| act_level_o | output | 40 | Active current levels, channel n at bits [5n+4:5n] |
| act_duty_o | output | 48 | Active duty codes, channel n at bits [6n+5:6n] |
| act_enable_o | output | 8 | Active channel enable word, bit n = channel n |

## Verification
The hardest case to reach from the ports is a staged value that differs from the active one. The outputs cannot show it, so the bench brings it out through the read path. It writes with command 001 or a bulk command, reads back over a repeated START while checking that the active outputs still hold the old value, and then issues an apply and checks the outputs again. Reserved commands and writes to the status index or to unmapped indices are checked the same way, by reading back the registers they could have changed.

// File: rtl/led_cmd_pkg.sv
package led_cmd_pkg;
  localparam int IDX_W = 5;

  localparam logic [2:0] CMD_APPLY    = 3'b000;
  localparam logic [2:0] CMD_WRITE    = 3'b001;
  localparam logic [2:0] CMD_WR_APPLY = 3'b010;
  localparam logic [2:0] CMD_ALL_LVL  = 3'b011;
  localparam logic [2:0] CMD_ALL_DUTY = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_ACK_ADDR,
    ST_RX_CMD,
    ST_ACK_CMD,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } eng_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
  // data edges while clock stays high
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import led_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_o,
  output logic             bulk_lvl_o,
  output logic             bulk_duty_o,
  output logic             apply_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  eng_state_e state_q;
  logic [7:0] sh_q;
  logic [2:0] cnt_q;
  logic       got8_q;
  logic       rw_q;
  logic [2:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      cnt_q       <= '0;
      got8_q      <= 1'b0;
      rw_q        <= 1'b0;
      cmd_q       <= '0;
      sda_oe_o    <= 1'b0;
      rd_idx_o    <= '0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
      wr_o        <= 1'b0;
      bulk_lvl_o  <= 1'b0;
      bulk_duty_o <= 1'b0;
      apply_o     <= 1'b0;
    end else begin
      wr_o        <= 1'b0;
      bulk_lvl_o  <= 1'b0;
      bulk_duty_o <= 1'b0;
      apply_o     <= 1'b0;
      if (start_i) begin
        state_q  <= ST_RX_ADDR;
        cnt_q    <= '0;
        got8_q   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_RX_ADDR, ST_RX_CMD, ST_RX_DATA: begin
            if (scl_rise_i) begin
              sh_q   <= {sh_q[6:0], sda_i};
              cnt_q  <= cnt_q + 3'd1;
              got8_q <= (cnt_q == 3'd7);
            end else if (scl_fall_i && got8_q) begin
              got8_q <= 1'b0;
              cnt_q  <= '0;
              if (state_q == ST_RX_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_q     <= sh_q[0];
                  sda_oe_o <= 1'b1;
                  state_q  <= ST_ACK_ADDR;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_RX_CMD) begin
                cmd_q    <= sh_q[7:5];
                wr_idx_o <= sh_q[4:0];
                sda_oe_o <= 1'b1;
                state_q  <= ST_ACK_CMD;
                if (sh_q[7:5] == CMD_WRITE) rd_idx_o <= sh_q[4:0];
                if (sh_q[7:5] == CMD_APPLY) apply_o <= 1'b1;
              end else begin
                wr_data_o <= sh_q;
                sda_oe_o  <= 1'b1;
                state_q   <= ST_ACK_DATA;
                case (cmd_q)
                  CMD_WRITE:    wr_o <= 1'b1;
                  CMD_WR_APPLY: begin
                    wr_o    <= 1'b1;
                    apply_o <= 1'b1;
                  end
                  CMD_ALL_LVL:  bulk_lvl_o  <= 1'b1;
                  CMD_ALL_DUTY: bulk_duty_o <= 1'b1;
                  default: ;
                endcase
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                cnt_q    <= '0;
                state_q  <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RX_CMD;
              end
            end
          end
          ST_ACK_CMD: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RX_DATA;
            end
          end
          ST_ACK_DATA: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_IGNORE;
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 3'd7) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
                cnt_q    <= cnt_q + 3'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) state_q <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/led_cmd_regfile.sv
module led_cmd_regfile
  import led_cmd_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int LVL_W  = 5,
  parameter int DUTY_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    bulk_lvl_i,
  input  logic                    bulk_duty_i,
  input  logic                    apply_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [7:0]              wr_data_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  input  logic [7:0]              status_i,
  output logic [7:0]              rd_data_o,
  output logic [N_CH*LVL_W-1:0]   act_level_o,
  output logic [N_CH*DUTY_W-1:0]  act_duty_o,
  output logic [N_CH-1:0]         act_enable_o
);
  localparam int DUTY_BASE = N_CH;
  localparam logic [IDX_W-1:0] EN_IDX   = IDX_W'(2 * N_CH);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(2 * N_CH + 1);

  logic [LVL_W-1:0]  lvl_q  [N_CH];
  logic [LVL_W-1:0]  lvl_n  [N_CH];
  logic [LVL_W-1:0]  lvl_a  [N_CH];
  logic [DUTY_W-1:0] duty_q [N_CH];
  logic [DUTY_W-1:0] duty_n [N_CH];
  logic [DUTY_W-1:0] duty_a [N_CH];
  logic [N_CH-1:0]   en_q, en_n, en_a;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      lvl_n[i]  = lvl_q[i];
      duty_n[i] = duty_q[i];
      if (bulk_lvl_i || (wr_i && wr_idx_i == IDX_W'(i)))
        lvl_n[i] = wr_data_i[LVL_W-1:0];
      if (bulk_duty_i || (wr_i && wr_idx_i == IDX_W'(DUTY_BASE + i)))
        duty_n[i] = wr_data_i[DUTY_W-1:0];
    end
    en_n = (wr_i && wr_idx_i == EN_IDX) ? wr_data_i[N_CH-1:0] : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) begin
        lvl_q[i]  <= '0;
        lvl_a[i]  <= '0;
        duty_q[i] <= '0;
        duty_a[i] <= '0;
      end
      en_q <= '0;
      en_a <= '0;
    end else begin
      lvl_q  <= lvl_n;
      duty_q <= duty_n;
      en_q   <= en_n;
      if (apply_i) begin
        lvl_a  <= lvl_n;
        duty_a <= duty_n;
        en_a   <= en_n;
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_idx_i == IDX_W'(i))             rd_data_o = 8'(lvl_q[i]);
      if (rd_idx_i == IDX_W'(DUTY_BASE + i)) rd_data_o = 8'(duty_q[i]);
    end
    if (rd_idx_i == EN_IDX)   rd_data_o = 8'(en_q);
    if (rd_idx_i == STAT_IDX) rd_data_o = status_i;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_pack
    assign act_level_o[g*LVL_W +: LVL_W]   = lvl_a[g];
    assign act_duty_o[g*DUTY_W +: DUTY_W]  = duty_a[g];
  end
  assign act_enable_o = en_a;
endmodule

// File: rtl/led_cmd_i2c_slave.sv
module led_cmd_i2c_slave
  import led_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1B,
  parameter int N_CH   = 8,
  parameter int LVL_W  = 5,
  parameter int DUTY_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [7:0]             status_i,
  output logic                   sda_oe_o,
  output logic                   bus_activity_o,
  output logic [N_CH*LVL_W-1:0]  act_level_o,
  output logic [N_CH*DUTY_W-1:0] act_duty_o,
  output logic [N_CH-1:0]        act_enable_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr, bulk_lvl, bulk_duty, apply;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [7:0] wr_data, rd_data;

  i2c_line_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_cmd_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_i       (sda_s),
    .rd_data_i   (rd_data),
    .sda_oe_o    (sda_oe_o),
    .rd_idx_o    (rd_idx),
    .wr_o        (wr),
    .bulk_lvl_o  (bulk_lvl),
    .bulk_duty_o (bulk_duty),
    .apply_o     (apply),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data)
  );

  led_cmd_regfile #(.N_CH(N_CH), .LVL_W(LVL_W), .DUTY_W(DUTY_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .bulk_lvl_i   (bulk_lvl),
    .bulk_duty_i  (bulk_duty),
    .apply_i      (apply),
    .wr_idx_i     (wr_idx),
    .wr_data_i    (wr_data),
    .rd_idx_i     (rd_idx),
    .status_i     (status_i),
    .rd_data_o    (rd_data),
    .act_level_o  (act_level_o),
    .act_duty_o   (act_duty_o),
    .act_enable_o (act_enable_o)
  );

  assign bus_activity_o = start_det;
endmodule

// File: rtl/led_cmd_i2c_slave_chk.sv
module led_cmd_i2c_slave_chk #(
  parameter int N_CH   = 8,
  parameter int LVL_W  = 5,
  parameter int DUTY_W = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   scl_s,
  input logic                   stop_det,
  input logic                   apply,
  input logic                   sda_oe_o,
  input logic                   bus_activity_o,
  input logic [N_CH*LVL_W-1:0]  act_level_o,
  input logic [N_CH*DUTY_W-1:0] act_duty_o,
  input logic [N_CH-1:0]        act_enable_o
);
  // R11
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_activity_o |=> !bus_activity_o);

  // R3 / R6: active set moves only on an apply
  a_r3_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> ($stable(act_level_o) && $stable(act_duty_o) && $stable(act_enable_o)));

  // R4
  a_r4_apply_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |=> !apply);

  // R12
  a_r12_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  a_r12_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
endmodule

bind led_cmd_i2c_slave led_cmd_i2c_slave_chk #(
  .N_CH(N_CH), .LVL_W(LVL_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_s          (scl_s),
  .stop_det       (stop_det),
  .apply          (apply),
  .sda_oe_o       (sda_oe_o),
  .bus_activity_o (bus_activity_o),
  .act_level_o    (act_level_o),
  .act_duty_o     (act_duty_o),
  .act_enable_o   (act_enable_o)
);

// File: tb/sim_led_cmd_i2c_slave.sv
module sim_led_cmd_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] status = 8'h5A;
  logic sda_oe, bus_act;
  logic [39:0] act_level;
  logic [47:0] act_duty;
  logic [7:0]  act_en;
  wire sda_line = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fail = 0;
  int act_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_cmd_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .status_i(status), .sda_oe_o(sda_oe), .bus_activity_o(bus_act),
    .act_level_o(act_level), .act_duty_o(act_duty), .act_enable_o(act_en)
  );

  always @(posedge clk) if (bus_act) act_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b0; wclk(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b1; wclk(HALF);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF/2);
    ack = ~sda_line;
    wclk(HALF/2);
    scl_m = 1'b0; wclk(HALF);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(HALF);
      scl_m = 1'b1; wclk(HALF/2);
      b[i] = sda_line;
      wclk(HALF/2);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wclk(HALF);   // NACK
    scl_m = 1'b1; wclk(HALF);
    scl_m = 1'b0; wclk(HALF);
  endtask

  // one write frame; returns the ANDed acks
  task automatic frame(input logic [6:0] addr, input logic [2:0] cmd, input logic [4:0] idx,
                       input logic [7:0] data, input bit with_data, output logic acks);
    logic a0, a1, a2;
    a2 = 1'b1;
    bus_start();
    wr_byte({addr, 1'b0}, a0);
    wr_byte({cmd, idx}, a1);
    if (with_data) wr_byte(data, a2);
    bus_stop();
    wclk(4);
    acks = a0 & a1 & a2;
  endtask

  task automatic reg_read(input logic [4:0] idx, output logic [7:0] d);
    logic a;
    bus_start();
    wr_byte(8'h36, a);
    wr_byte({3'b001, idx}, a);
    bus_start();
    wr_byte(8'h37, a);
    rd_byte(d);
    bus_stop();
    wclk(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 level", 64'(act_level), 0);
    chk("R10 duty", 64'(act_duty), 0);
    chk("R10 enable", 64'(act_en), 0);
    chk("R10 sda", 64'(sda_oe), 0);
    reg_read(5'h08, d);
    chk("R10 staged duty", 64'(d), 0);
  endtask

  task automatic t_address();
    logic a0;
    logic [7:0] d;
    bus_start();
    wr_byte({7'h1D, 1'b0}, a0);
    chk("R1 foreign addr nack", 64'(a0), 0);
    wr_byte({3'b010, 5'h10}, a0);
    wr_byte(8'hFF, a0);
    bus_stop(); wclk(4);
    chk("R1 foreign frame no effect", 64'(act_en), 0);
    reg_read(5'h10, d);
    chk("R1 foreign frame staged", 64'(d), 0);
  endtask

  task automatic t_stage();
    logic acks;
    logic [7:0] d;
    int c0;
    frame(7'h1B, 3'b001, 5'h02, 8'h1F, 1, acks);
    chk("R2 acks", 64'(acks), 1);
    chk("R3 active unchanged", 64'(act_level), 0);
    c0 = act_cnt;
    reg_read(5'h02, d);
    chk("R8 read staged level", 64'(d), 64'h1F);
    chk("R11 start pulses", 64'(act_cnt - c0), 2);
  endtask

  task automatic t_apply();
    logic acks;
    frame(7'h1B, 3'b000, 5'h1F, 8'h00, 0, acks);
    chk("R4 ack no data", 64'(acks), 1);
    chk("R4 applied", 64'(act_level), 64'h1F << 10);
    frame(7'h1B, 3'b000, 5'h03, 8'hFF, 1, acks);
    chk("R4 data byte ack", 64'(acks), 1);
    chk("R4 data ignored", 64'(act_level), 64'h1F << 10);
  endtask

  task automatic t_write_apply();
    logic acks;
    frame(7'h1B, 3'b010, 5'h10, 8'hA5, 1, acks);
    chk("R5 enable applied", 64'(act_en), 64'hA5);
    frame(7'h1B, 3'b010, 5'h09, 8'h2A, 1, acks);
    chk("R5 duty applied", 64'(act_duty), 64'h2A << 6);
  endtask

  task automatic t_bulk();
    logic acks;
    logic [7:0] d;
    logic [63:0] exp_l, exp_d;
    frame(7'h1B, 3'b011, 5'h00, 8'hE7, 1, acks);
    chk("R6 bulk level staged only", 64'(act_level), 64'h1F << 10);
    reg_read(5'h05, d);
    chk("R6 bulk level read", 64'(d), 64'h07);
    frame(7'h1B, 3'b100, 5'h11, 8'hFF, 1, acks);
    reg_read(5'h0C, d);
    chk("R6 bulk duty read", 64'(d), 64'h3F);
    chk("R6 bulk duty staged only", 64'(act_duty), 64'h2A << 6);
    frame(7'h1B, 3'b000, 5'h00, 8'h00, 0, acks);
    exp_l = 0; exp_d = 0;
    for (int i = 0; i < 8; i++) begin
      exp_l = exp_l | (64'h07 << (5 * i));
      exp_d = exp_d | (64'h3F << (6 * i));
    end
    chk("R6 level after apply", 64'(act_level), exp_l);
    chk("R6 duty after apply", 64'(act_duty), exp_d);
  endtask

  task automatic t_reserved();
    logic acks;
    logic [7:0] d;
    logic [39:0] l0;
    l0 = act_level;
    for (int c = 5; c < 8; c++) begin
      frame(7'h1B, 3'(c), 5'h00, 8'h00, 1, acks);
      chk("R7 reserved acked", 64'(acks), 1);
    end
    reg_read(5'h00, d);
    chk("R7 level kept", 64'(d), 64'h07);
    reg_read(5'h10, d);
    chk("R7 enable kept", 64'(d), 64'hA5);
    frame(7'h1B, 3'b000, 5'h00, 8'h00, 0, acks);
    chk("R7 active kept", 64'(act_level), 64'(l0));
  endtask

  task automatic t_status();
    logic acks;
    logic [7:0] d;
    reg_read(5'h11, d);
    chk("R8 status read", 64'(d), 64'h5A);
    frame(7'h1B, 3'b001, 5'h11, 8'h00, 1, acks);
    reg_read(5'h11, d);
    chk("R9 status not written", 64'(d), 64'h5A);
    frame(7'h1B, 3'b001, 5'h15, 8'h33, 1, acks);
    reg_read(5'h15, d);
    chk("R9 unmapped reads zero", 64'(d), 0);
    reg_read(5'h10, d);
    chk("R9 enable untouched", 64'(d), 64'hA5);
    frame(7'h1B, 3'b001, 5'h00, 8'hFF, 1, acks);
    reg_read(5'h00, d);
    chk("R8 level truncated", 64'(d), 64'h1F);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_address();
    t_stage();
    t_apply();
    t_write_apply();
    t_bulk();
    t_reserved();
    t_status();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule